// File: doc/BRIEF.md
# Byte-Wide SPI Master with CPU Register Window

This block is a serial peripheral interface master for a CPU. The CPU sees three byte-wide registers on a small synchronous bus. A write to the data register starts an eight-bit exchange on the serial clock, MOSI and MISO pins. The exchange is full duplex and sends the most significant bit first. When the eighth incoming bit is sampled, the received byte moves into a receive buffer and a completion flag rises. A later read of the data register returns the byte held in that buffer.

A second flag records a data write made while an exchange is still running. That write is thrown away. Both flags are cleared in two steps: the CPU first reads the status register while the flag is visible, and then reads or writes the data register. The control register sets the clock polarity, the clock phase and a 2-bit rate code. A double-speed bit in the status register halves the selected divider. At its fastest, the serial clock period is two system clocks. Chip select is handled outside the block.

Top module: `spi_byte_master`

## Requirements
- R1: Register addresses are 0 = control, 1 = status and 2 = data. Address 3 reads zero. Control bit 3 is CPOL, bit 2 is CPHA and bits 1:0 are the rate code, and control bits 7:4 read zero. Status bit 7 is the completion flag, bit 6 is the collision flag and bit 0 is the writable double-speed bit. Status bits 5:1 always read zero. Everything resets to zero.
- R2: A data write while no exchange runs shifts that byte out on MOSI, MSB first, over eight serial clock cycles.
- R3: A data read returns the receive buffer. The buffer changes only when an exchange completes, so during a new exchange it still holds the previous byte.
- R4: The completion flag sets in the same clock edge in which the eighth MISO bit is sampled. At that moment the assembled byte (first bit received as MSB) is copied into the receive buffer.
- R5: A data write during an exchange sets the collision flag. The written byte is discarded, and the byte already being shifted is sent unchanged.
- R6: Each flag clears only on a data access (read or write) that follows a status read made while that flag was set. A data access without such a prior status read leaves the flags set.
- R7: When idle and at the end of each exchange, SCK rests at CPOL. With CPHA=0, MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R8: With CPHA=0, MOSI carries the byte's MSB from the cycle after the starting write, before the first SCK edge.
- R9: SCK half-period in system clocks is 2, 8, 32 or 64 for rate codes 0 to 3 (a full period of 4, 16, 64 or 128). The double-speed bit halves these to 1, 4, 16 or 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (marks an access for flag clearing) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Faults in the edge counter or the sample/setup choice show up within one exchange. The bench's slave model then sees a wrong byte, the CPU reads a wrong byte, or SCK ends away from CPOL, and all of these are checked as soon as the exchange completes. A wrong divider changes the SCK half-period, which the bench measures from SCK toggles within the same exchange. A fault in the flag-arming state shows up on the next status read, which follows the next data access, so every clearing path is exercised with and without the prior status read.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int WORD_W  = 8;
  localparam int HALF_W  = 7;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  localparam int BIT_DONE = 7;
  localparam int BIT_COLL = 6;
  localparam int BIT_DBL  = 0;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } spi_ctrl_t;

  // Half-period of SCK in system clocks for a rate code and speed bit.
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate,
                                                     input logic dbl);
    logic [HALF_W-1:0] h;
    case (rate)
      2'd0:    h = HALF_W'(2);
      2'd1:    h = HALF_W'(8);
      2'd2:    h = HALF_W'(32);
      default: h = HALF_W'(64);
    endcase
    return dbl ? (h >> 1) : h;
  endfunction
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div
  import spi_master_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [1:0] rate_i,
  input  logic       dbl_i,
  output logic       tick_o
);
  logic [HALF_W-1:0] cnt_q, cnt_n, half;

  always_comb begin
    half   = half_period(rate_i, dbl_i);
    tick_o = run_i && (cnt_q == half - HALF_W'(1));
    if (restart_i || !run_i || tick_o) cnt_n = '0;
    else                               cnt_n = cnt_q + HALF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < half));
  p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] data_i,
  input  logic         cpol_i,
  input  logic         cpha_i,
  input  logic         tick_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         sclk_o,
  output logic         mosi_o,
  output logic         byte_done_o,
  output logic [W-1:0] rx_word_o
);
  localparam int EW = $clog2(2 * W);
  localparam int SW = $clog2(W);

  logic         busy_q, busy_n, sclk_q, sclk_n, mosi_q, mosi_n;
  logic [W-1:0] tx_q, tx_n, rx_q, rx_n;
  logic [EW-1:0] edge_q, edge_n;
  logic [SW-1:0] smp_q, smp_n;
  logic         leading, sample_edge;

  always_comb begin
    busy_n = busy_q; sclk_n = sclk_q; mosi_n = mosi_q;
    tx_n = tx_q; rx_n = rx_q; edge_n = edge_q; smp_n = smp_q;
    leading     = ~edge_q[0];
    sample_edge = leading ^ cpha_i;
    byte_done_o = 1'b0;
    rx_word_o   = {rx_q[W-2:0], miso_i};
    if (!busy_q) begin
      sclk_n = cpol_i;
      if (start_i) begin
        busy_n = 1'b1;
        edge_n = '0;
        smp_n  = '0;
        if (!cpha_i) begin
          mosi_n = data_i[W-1];
          tx_n   = data_i << 1;
        end else begin
          tx_n   = data_i;
        end
      end
    end else if (tick_i) begin
      sclk_n = ~sclk_q;
      edge_n = edge_q + EW'(1);
      if (sample_edge) begin
        rx_n  = rx_word_o;
        smp_n = smp_q + SW'(1);
        if (smp_q == SW'(W - 1)) byte_done_o = 1'b1;
      end else begin
        mosi_n = tx_q[W-1];
        tx_n   = tx_q << 1;
      end
      if (edge_q == EW'(2 * W - 1)) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      tx_q <= '0; rx_q <= '0; edge_q <= '0; smp_q <= '0;
    end else begin
      busy_q <= busy_n; sclk_q <= sclk_n; mosi_q <= mosi_n;
      tx_q <= tx_n; rx_q <= rx_n; edge_q <= edge_n; smp_q <= smp_n;
    end
  end

  assign busy_o = busy_q;
  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;

  // R7: each exchange leaves SCK at the idle polarity
  p_end_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (sclk_q == cpol_i));
  // R7: MOSI never moves on a sampling edge
  p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tick_i && sample_edge) |=> $stable(mosi_q));
  // R9: SCK only moves on a divider tick during an exchange
  p_toggle_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(sclk_q)) |-> $past(tick_i));
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_master_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              byte_done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              start_o,
  output spi_ctrl_t         ctrl_o,
  output logic              dbl_o
);
  spi_ctrl_t         ctrl_q, ctrl_n;
  logic              dbl_q, dbl_n, done_q, done_n, coll_q, coll_n;
  logic [1:0]        arm_q, arm_n;
  logic [WORD_W-1:0] rxbuf_q, rxbuf_n;
  logic              data_acc, data_wr, stat_rd, coll_ev;

  always_comb begin
    data_wr  = wr_i && (sel_i == ADR_DATA);
    data_acc = (wr_i || rd_i) && (sel_i == ADR_DATA);
    stat_rd  = rd_i && (sel_i == ADR_STAT);
    start_o  = data_wr && !busy_i;
    coll_ev  = data_wr && busy_i;

    ctrl_n  = (wr_i && sel_i == ADR_CTRL) ? spi_ctrl_t'(wdata_i[3:0]) : ctrl_q;
    dbl_n   = (wr_i && sel_i == ADR_STAT) ? wdata_i[BIT_DBL] : dbl_q;
    rxbuf_n = byte_done_i ? rx_word_i : rxbuf_q;

    done_n = done_q;
    if (data_acc && arm_q[1]) done_n = 1'b0;
    if (byte_done_i)          done_n = 1'b1;
    coll_n = coll_q;
    if (data_acc && arm_q[0]) coll_n = 1'b0;
    if (coll_ev)              coll_n = 1'b1;

    arm_n = arm_q;
    if (data_acc) arm_n = 2'b00;
    if (stat_rd)  arm_n = {done_q, coll_q};

    rdata_o = '0;
    case (sel_i)
      ADR_CTRL: rdata_o[3:0] = ctrl_q;
      ADR_STAT: begin
        rdata_o[BIT_DONE] = done_q;
        rdata_o[BIT_COLL] = coll_q;
        rdata_o[BIT_DBL]  = dbl_q;
      end
      ADR_DATA: rdata_o = rxbuf_q;
      default:  rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; dbl_q <= 1'b0; done_q <= 1'b0; coll_q <= 1'b0;
      arm_q <= 2'b00; rxbuf_q <= '0;
    end else begin
      ctrl_q <= ctrl_n; dbl_q <= dbl_n; done_q <= done_n; coll_q <= coll_n;
      arm_q <= arm_n; rxbuf_q <= rxbuf_n;
    end
  end

  assign ctrl_o = ctrl_q;
  assign dbl_o  = dbl_q;

  p_done_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(byte_done_i));
  p_coll_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_q) |-> $past(busy_i));
  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(arm_q[1]));
  p_coll_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coll_q) |-> $past(arm_q[0]));
  p_buf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_done_i) |-> $stable(rxbuf_q));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_master_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  spi_ctrl_t         ctrl;
  logic              dbl, start, busy, tick, byte_done;
  logic [WORD_W-1:0] rx_word;

  spi_reg_file u_regs (
    .clk(clk), .rst_n(rst_n), .sel_i(bus_sel), .wr_i(bus_wr), .rd_i(bus_rd),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .busy_i(busy),
    .byte_done_i(byte_done), .rx_word_i(rx_word), .start_o(start),
    .ctrl_o(ctrl), .dbl_o(dbl)
  );

  spi_rate_div u_div (
    .clk(clk), .rst_n(rst_n), .run_i(busy), .restart_i(start),
    .rate_i(ctrl.rate), .dbl_i(dbl), .tick_o(tick)
  );

  spi_shift_engine #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_i(start), .data_i(bus_wdata),
    .cpol_i(ctrl.cpol), .cpha_i(ctrl.cpha), .tick_i(tick), .miso_i(spi_miso),
    .busy_o(busy), .sclk_o(spi_sck), .mosi_o(spi_mosi),
    .byte_done_o(byte_done), .rx_word_o(rx_word)
  );
endmodule

// File: tb/spi_byte_master_test.sv
`timescale 1ns/1ps
module spi_byte_master_test;
  logic       clk, rst_n, bus_wr, bus_rd, spi_miso;
  logic [1:0] bus_sel;
  logic [7:0] bus_wdata, bus_rdata;
  logic       spi_sck, spi_mosi;

  int n_chk = 0, n_bad = 0;
  logic [7:0] prev_rx;

  // slave model state
  logic       s_on, m_cpol, m_cpha;
  logic [7:0] s_tx, s_rx;
  int         s_cnt;
  // SCK half-period monitor
  logic       last_sck;
  int         run_cnt, last_half;

  spi_byte_master uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(spi_sck) begin
    if (s_on) begin
      if (((spi_sck != m_cpol) ? 1'b1 : 1'b0) ^ m_cpha) begin
        s_rx  = {s_rx[6:0], spi_mosi};
        s_cnt = s_cnt + 1;
      end else if (m_cpha == 1'b0) begin
        s_tx = s_tx << 1;
        spi_miso = s_tx[7];
      end else begin
        spi_miso = s_tx[7];
        s_tx = s_tx << 1;
      end
    end
  end

  always @(negedge clk) begin
    if (spi_sck !== last_sck) begin
      last_half = run_cnt;
      run_cnt   = 1;
      last_sck  = spi_sck;
    end else run_cnt = run_cnt + 1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = 8'h00;
    for (int i = 0; i < 4000 && st[7] == 1'b0; i++) bus_read(2'd1, st);
  endtask

  function automatic int exp_half(input logic [1:0] r, input logic d);
    int b;
    b = (r == 2'd0) ? 4 : (r == 2'd1) ? 16 : (r == 2'd2) ? 64 : 128;
    return d ? b / 4 : b / 2;
  endfunction

  task automatic slave_arm(input logic cp, input logic ch, input logic [7:0] b);
    m_cpol = cp; m_cpha = ch; s_tx = b; s_rx = 8'h00; s_cnt = 0;
    if (!ch) spi_miso = b[7];
    s_on = 1'b1;
  endtask

  task automatic test_reset();
    logic [7:0] v;
    bus_read(2'd1, v); check("R1 status reset", v, 8'h00);
    bus_read(2'd0, v); check("R1 ctrl reset", v, 8'h00);
    bus_read(2'd2, v); check("R1 data reset", v, 8'h00);
    check("R7 sck reset", {7'd0, spi_sck}, 8'h00);
    bus_write(2'd0, 8'hFF); bus_read(2'd0, v); check("R1 ctrl mask", v, 8'h0F);
    bus_write(2'd1, 8'hFF); bus_read(2'd1, v); check("R1 status reserved", v, 8'h01);
    bus_read(2'd3, v); check("R1 unused address", v, 8'h00);
    bus_write(2'd1, 8'h00); bus_write(2'd0, 8'h00);
  endtask

  task automatic test_mode(input logic cp, input logic ch, input logic [1:0] r,
                           input logic d, input logic [7:0] tx, input logic [7:0] srx);
    logic [7:0] v, st;
    bus_write(2'd0, {4'd0, cp, ch, r});
    bus_write(2'd1, {7'd0, d});
    slave_arm(cp, ch, srx);
    bus_write(2'd2, tx);
    if (!ch) begin
      check("R8 mosi preload", {7'd0, spi_mosi}, {7'd0, tx[7]});
      check("R8 sck still idle", {7'd0, spi_sck}, {7'd0, cp});
    end
    bus_read(2'd2, v); check("R3 buffer holds old byte", v, prev_rx);
    wait_done(st);
    check("R4 done flag", st, {2'b10, 5'd0, d});
    check("R2 slave received", s_rx, tx);
    check("R4 eight bits sampled", 8'(s_cnt), 8'd8);
    bus_read(2'd2, v); check("R4 received byte", v, srx);
    prev_rx = srx;
    repeat (2 * exp_half(r, d) + 4) @(negedge clk);
    check("R7 sck idle level", {7'd0, spi_sck}, {7'd0, cp});
    check("R9 half period", 8'(last_half), 8'(exp_half(r, d)));
    bus_read(2'd1, st); check("R6 flags cleared", st, {7'd0, d});
    s_on = 1'b0;
  endtask

  task automatic test_collision();
    logic [7:0] v, st;
    bus_write(2'd0, 8'h01); bus_write(2'd1, 8'h00);
    slave_arm(1'b0, 1'b0, 8'h96);
    bus_write(2'd2, 8'hC3);
    bus_write(2'd2, 8'h18);
    bus_read(2'd1, st); check("R5 collision flag", st, 8'h40);
    wait_done(st);
    check("R5 both flags", st, 8'hC0);
    check("R5 original byte sent", s_rx, 8'hC3);
    bus_read(2'd2, v); check("R5 received", v, 8'h96);
    prev_rx = 8'h96;
    bus_read(2'd1, st); check("R6 both cleared", st, 8'h00);
    repeat (40) @(negedge clk);
    s_on = 1'b0;
  endtask

  task automatic test_clear_order();
    logic [7:0] v, st;
    bus_write(2'd0, 8'h00); bus_write(2'd1, 8'h01);
    slave_arm(1'b0, 1'b0, 8'h5A);
    bus_write(2'd2, 8'h81);
    repeat (40) @(negedge clk);
    bus_read(2'd2, v); check("R3 buffer after exchange", v, 8'h5A);
    bus_read(2'd1, st); check("R6 no clear without status read", st, 8'h81);
    bus_read(2'd2, v);
    bus_read(2'd1, st); check("R6 clear after sequence", st, 8'h01);
    bus_read(2'd2, v);
    prev_rx = 8'h5A;
    s_on = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_sel = 2'd0; bus_wdata = 8'h00;
    spi_miso = 1'b0; s_on = 1'b0; m_cpol = 1'b0; m_cpha = 1'b0; s_tx = 8'h00;
    s_rx = 8'h00; s_cnt = 0; last_sck = 1'b0; run_cnt = 0; last_half = 0;
    prev_rx = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_mode(1'b0, 1'b0, 2'd0, 1'b0, 8'hA5, 8'h3C);
    test_mode(1'b0, 1'b1, 2'd1, 1'b0, 8'h4E, 8'hD1);
    test_mode(1'b1, 1'b0, 2'd2, 1'b1, 8'h17, 8'hE8);
    test_mode(1'b1, 1'b1, 2'd3, 1'b0, 8'hF0, 8'h0F);
    test_mode(1'b0, 1'b0, 2'd0, 1'b1, 8'h69, 8'hB2);
    test_mode(1'b1, 1'b1, 2'd1, 1'b1, 8'h80, 8'h01);
    test_collision();
    test_clear_order();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule